// File: doc/BRIEF.md
# Inter-processor interrupt dispatcher

This block turns single register writes into commands aimed at one processor of a multi-processor cluster. A write to the dispatch register carries a 2-bit command kind, a target processor number and a 6-bit vector. The kinds are: post the vector as an interrupt, reset the processor and let it run, stop it so that interrupts no longer wake it, and let a stopped processor run again. The block drops writes whose target is outside the configured processor count. It issues each accepted command as a one-cycle strobe with its kind, target and vector on separate outputs, and the consuming logic acts on that strobe.

The block keeps one run bit per processor. The run bit decides whether an interrupt post reaches that processor. A reset request is legal only when its vector equals the power-on-reset code. An illegal request does nothing except raise a sticky error flag, which software reads on an output and clears with a pulse.

Top module: `ipi_dispatch`

## Requirements
- R1: After reset, `cmd_valid` and `reset_err` are 0 and every bit of `run_status` is 1.
- R2: Write data fields are kind = bits 17:16, target = bits 12:8, vector = bits 5:0, and all other bits are ignored. An accepted write sampled at clock edge N raises `cmd_valid` for exactly the cycle after edge N, with the decoded fields on `cmd_kind`, `cmd_cpu` and `cmd_vec`.
- R3: Kind 0 (post) to a target whose run bit is 1 is issued. Kind 0 to a target whose run bit is 0 gives no strobe.
- R4: Kind 1 (reset) with vector equal to `POR_VEC` (default 1) is issued, and the target's run bit becomes 1.
- R5: Kind 1 with any other vector gives no strobe, leaves `run_status` unchanged and sets `reset_err`.
- R6: Kind 2 (idle) is issued, and the target's run bit becomes 0.
- R7: Kind 3 (resume) is issued, and the target's run bit becomes 1.
- R8: A write whose target is at or above `NUM_CPU` gives no strobe and changes neither `run_status` nor `reset_err`, whatever its kind or vector.
- R9: An `err_clr` pulse clears `reset_err`. If an illegal reset arrives in the same cycle, the flag stays set.
- R10: Writes on consecutive cycles each produce their own strobe on consecutive cycles. Each one sees the run bits left by the write before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Dispatch register write strobe |
| wr_data | input | 32 | Dispatch register write data |
| err_clr | input | 1 | Clears the sticky reset error flag |
| cmd_valid | output | 1 | One-cycle command strobe |
| cmd_kind | output | 2 | Command kind: 0 post, 1 reset, 2 idle, 3 resume |
| cmd_cpu | output | 5 | Target processor |
| cmd_vec | output | 6 | Vector |
| run_status | output | NUM_CPU | Run bit per processor |
| reset_err | output | 1 | Sticky illegal-reset flag |

## Verification
There is exactly one register stage between input and output. The strobe, the new run bit and the error flag therefore all belong to the clock edge that samples the write, and they are visible one cycle after the write is driven. A dropped write must leave the strobe low in that same cycle. For every write the bench queues an expected item holding the strobe, the fields, the run vector and the flag. A monitor samples 1 ns after each rising edge and pops exactly one item per write cycle. In idle cycles it requires the strobe to be low and the state to be unchanged, so a late, early or doubled strobe is caught.

// File: rtl/ipi_pkg.sv
package ipi_pkg;

    localparam int DISP_W   = 32;
    localparam int KIND_LSB = 16;
    localparam int CPU_LSB  = 8;
    localparam int VEC_LSB  = 0;
    localparam int KIND_W   = 2;
    localparam int CPU_W    = 5;
    localparam int VEC_W    = 6;

    typedef enum logic [KIND_W-1:0] {
        IPI_POST   = 2'd0,
        IPI_RESET  = 2'd1,
        IPI_IDLE   = 2'd2,
        IPI_RESUME = 2'd3
    } ipi_kind_e;

    typedef struct packed {
        ipi_kind_e          kind;
        logic [CPU_W-1:0]   cpu;
        logic [VEC_W-1:0]   vec;
    } ipi_cmd_t;

    // Pull the three fields out of a dispatch write word.
    function automatic ipi_cmd_t unpack_cmd(input logic [DISP_W-1:0] d);
        ipi_cmd_t c;
        c.kind = ipi_kind_e'(d[KIND_LSB +: KIND_W]);
        c.cpu  = d[CPU_LSB +: CPU_W];
        c.vec  = d[VEC_LSB +: VEC_W];
        return c;
    endfunction

endpackage

// File: rtl/ipi_decode.sv
module ipi_decode
    import ipi_pkg::*;
#(
    parameter int                NUM_CPU = 8,
    parameter logic [VEC_W-1:0]  POR_VEC = 6'h01
) (
    input  logic                wr_en,
    input  ipi_cmd_t            cmd,
    input  logic [NUM_CPU-1:0]  run_vec,
    output logic                issue,
    output logic                bad_reset,
    output logic [NUM_CPU-1:0]  run_set,
    output logic [NUM_CPU-1:0]  run_clr
);

    logic [NUM_CPU-1:0] sel;
    logic               tgt_run;
    logic               in_range;

    // One-hot select of the target; stays zero when the target is out of range.
    for (genvar i = 0; i < NUM_CPU; i++) begin : g_sel
        assign sel[i] = (cmd.cpu == CPU_W'(i));
    end

    assign in_range = |sel;
    assign tgt_run  = |(run_vec & sel);

    always_comb begin
        issue     = 1'b0;
        bad_reset = 1'b0;
        run_set   = '0;
        run_clr   = '0;
        if (wr_en && in_range) begin
            unique case (cmd.kind)
                IPI_POST: issue = tgt_run;
                IPI_RESET: begin
                    if (cmd.vec == POR_VEC) begin
                        issue   = 1'b1;
                        run_set = sel;
                    end else begin
                        bad_reset = 1'b1;
                    end
                end
                IPI_IDLE: begin
                    issue   = 1'b1;
                    run_clr = sel;
                end
                IPI_RESUME: begin
                    issue   = 1'b1;
                    run_set = sel;
                end
                default: issue = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/ipi_runstate.sv
module ipi_runstate #(
    parameter int                 NUM_CPU  = 8,
    parameter logic [NUM_CPU-1:0] RUN_INIT = '1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_CPU-1:0]  run_set,
    input  logic [NUM_CPU-1:0]  run_clr,
    output logic [NUM_CPU-1:0]  run_vec
);

    for (genvar i = 0; i < NUM_CPU; i++) begin : g_run
        always_ff @(posedge clk) begin
            if (rst)
                run_vec[i] <= RUN_INIT[i];
            else if (run_clr[i])
                run_vec[i] <= 1'b0;
            else if (run_set[i])
                run_vec[i] <= 1'b1;
        end
    end

endmodule

// File: rtl/ipi_issue.sv
module ipi_issue
    import ipi_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      issue,
    input  ipi_cmd_t  cmd,
    input  logic      bad_reset,
    input  logic      err_clr,
    output logic      cmd_valid,
    output ipi_cmd_t  cmd_q,
    output logic      err_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_valid <= 1'b0;
            cmd_q     <= '0;
        end else begin
            cmd_valid <= issue;
            if (issue)
                cmd_q <= cmd;
        end
    end

    // Sticky flag: a new illegal reset wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (rst)
            err_q <= 1'b0;
        else if (bad_reset)
            err_q <= 1'b1;
        else if (err_clr)
            err_q <= 1'b0;
    end

endmodule

// File: rtl/ipi_dispatch.sv
module ipi_dispatch
    import ipi_pkg::*;
#(
    parameter int                 NUM_CPU  = 8,
    parameter logic [VEC_W-1:0]   POR_VEC  = 6'h01,
    parameter logic [NUM_CPU-1:0] RUN_INIT = '1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [DISP_W-1:0]   wr_data,
    input  logic                err_clr,
    output logic                cmd_valid,
    output logic [KIND_W-1:0]   cmd_kind,
    output logic [CPU_W-1:0]    cmd_cpu,
    output logic [VEC_W-1:0]    cmd_vec,
    output logic [NUM_CPU-1:0]  run_status,
    output logic                reset_err
);

    ipi_cmd_t            cmd_in;
    ipi_cmd_t            cmd_q;
    logic                issue;
    logic                bad_reset;
    logic [NUM_CPU-1:0]  run_set;
    logic [NUM_CPU-1:0]  run_clr;

    assign cmd_in = unpack_cmd(wr_data);

    ipi_decode #(.NUM_CPU(NUM_CPU), .POR_VEC(POR_VEC)) u_decode (
        .wr_en     (wr_en),
        .cmd       (cmd_in),
        .run_vec   (run_status),
        .issue     (issue),
        .bad_reset (bad_reset),
        .run_set   (run_set),
        .run_clr   (run_clr)
    );

    ipi_runstate #(.NUM_CPU(NUM_CPU), .RUN_INIT(RUN_INIT)) u_run (
        .clk     (clk),
        .rst     (rst),
        .run_set (run_set),
        .run_clr (run_clr),
        .run_vec (run_status)
    );

    ipi_issue u_issue (
        .clk       (clk),
        .rst       (rst),
        .issue     (issue),
        .cmd       (cmd_in),
        .bad_reset (bad_reset),
        .err_clr   (err_clr),
        .cmd_valid (cmd_valid),
        .cmd_q     (cmd_q),
        .err_q     (reset_err)
    );

    assign cmd_kind = cmd_q.kind;
    assign cmd_cpu  = cmd_q.cpu;
    assign cmd_vec  = cmd_q.vec;

endmodule

// File: rtl/ipi_dispatch_chk.sv
module ipi_dispatch_chk
    import ipi_pkg::*;
#(
    parameter int                NUM_CPU = 8,
    parameter logic [VEC_W-1:0]  POR_VEC = 6'h01
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [DISP_W-1:0]   wr_data,
    input  logic                err_clr,
    input  logic                cmd_valid,
    input  logic [KIND_W-1:0]   cmd_kind,
    input  logic [CPU_W-1:0]    cmd_cpu,
    input  logic [VEC_W-1:0]    cmd_vec,
    input  logic [NUM_CPU-1:0]  run_status,
    input  logic                reset_err
);

    logic [KIND_W-1:0] w_kind;
    logic [CPU_W-1:0]  w_cpu;
    logic [VEC_W-1:0]  w_vec;
    logic              w_in;
    logic              w_run;
    logic              out_run;

    assign w_kind  = wr_data[KIND_LSB +: KIND_W];
    assign w_cpu   = wr_data[CPU_LSB +: CPU_W];
    assign w_vec   = wr_data[VEC_LSB +: VEC_W];
    assign w_in    = int'(w_cpu) < NUM_CPU;
    assign w_run   = |(run_status & (NUM_CPU'(1) << w_cpu));
    assign out_run = |(run_status & (NUM_CPU'(1) << cmd_cpu));

    AST_CPU_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> int'(cmd_cpu) < NUM_CPU); // R8

    AST_OUT_OF_RANGE_DROP: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !w_in) |=> (!cmd_valid && $stable(run_status))); // R8

    AST_RESET_LEGAL: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_kind == 2'd1) |-> (cmd_vec == POR_VEC && out_run)); // R4

    AST_BAD_RESET_FLAG: assert property (@(posedge clk) disable iff (rst)
        (wr_en && w_in && w_kind == 2'd1 && w_vec != POR_VEC)
        |=> (reset_err && !cmd_valid)); // R5

    AST_IDLE_STOPS: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_kind == 2'd2) |-> !out_run); // R6

    AST_RESUME_RUNS: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_kind == 2'd3) |-> out_run); // R7

    AST_POST_BLOCKED: assert property (@(posedge clk) disable iff (rst)
        (wr_en && w_in && w_kind == 2'd0 && !w_run) |=> !cmd_valid); // R3

    AST_STROBE_FROM_WRITE: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> $past(wr_en)); // R2

    AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (err_clr && !wr_en) |=> !reset_err); // R9

endmodule

bind ipi_dispatch ipi_dispatch_chk #(.NUM_CPU(NUM_CPU), .POR_VEC(POR_VEC)) u_chk (.*);

// File: tb/ipi_dispatch_tb.sv
`timescale 1ns/1ps
module ipi_dispatch_tb;

    localparam int NCPU = 8;
    localparam int POR  = 1;

    typedef struct {
        bit        v;
        int        kind;
        int        cpu;
        int        vec;
        bit [7:0]  run;
        bit        err;
        string     tag;
    } exp_t;

    logic        clk = 0;
    logic        rst = 1;
    logic        wr_en = 0;
    logic [31:0] wr_data = 0;
    logic        err_clr = 0;
    logic        cmd_valid;
    logic [1:0]  cmd_kind;
    logic [4:0]  cmd_cpu;
    logic [5:0]  cmd_vec;
    logic [7:0]  run_status;
    logic        reset_err;

    int   n_tests = 0;
    int   n_fail  = 0;
    bit   done    = 0;
    exp_t q[$];
    bit [7:0] mdl_run = '1;
    bit       mdl_err = 0;

    always #2 clk = ~clk;

    ipi_dispatch #(.NUM_CPU(NCPU)) u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .err_clr(err_clr),
        .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_cpu(cmd_cpu),
        .cmd_vec(cmd_vec), .run_status(run_status), .reset_err(reset_err)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Driver: one write per call, expected result pushed to the scoreboard.
    task automatic send(input int kind, input int cpu, input int vec,
                        input bit clr, input logic [31:0] extra, input string tag);
        exp_t e;
        bit   inr;
        bit   bad;
        @(negedge clk);
        wr_en   = 1;
        err_clr = clr;
        wr_data = extra & ~32'h0003_1F3F;
        wr_data[17:16] = 2'(kind);
        wr_data[12:8]  = 5'(cpu);
        wr_data[5:0]   = 6'(vec);
        inr = cpu < NCPU;
        bad = 0;
        e.v = 0;
        if (inr) begin
            case (kind)
                0: e.v = mdl_run[cpu];
                1: if (vec == POR) begin e.v = 1; mdl_run[cpu] = 1; end else bad = 1;
                2: begin e.v = 1; mdl_run[cpu] = 0; end
                default: begin e.v = 1; mdl_run[cpu] = 1; end
            endcase
        end
        if (bad) mdl_err = 1;
        else if (clr) mdl_err = 0;
        e.kind = kind; e.cpu = cpu; e.vec = vec;
        e.run = mdl_run; e.err = mdl_err; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic clear_only(input string tag);
        exp_t e;
        @(negedge clk);
        wr_en = 0; err_clr = 1;
        mdl_err = 0;
        e.v = 0; e.kind = 0; e.cpu = 0; e.vec = 0;
        e.run = mdl_run; e.err = 0; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            wr_en = 0; err_clr = 0;
        end
    endtask

    // Monitor: one register stage, so results appear right after the sampling edge.
    always @(posedge clk) begin
        #1;
        if (!rst && !done) begin
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                chk(cmd_valid == e.v, e.tag, "cmd_valid", cmd_valid, e.v);
                if (e.v && cmd_valid) begin
                    chk(cmd_kind == 2'(e.kind) && cmd_cpu == 5'(e.cpu) && cmd_vec == 6'(e.vec),
                        e.tag, "fields", {cmd_kind, cmd_cpu, cmd_vec},
                        {2'(e.kind), 5'(e.cpu), 6'(e.vec)});
                end
                chk(run_status == e.run, e.tag, "run_status", run_status, e.run);
                chk(reset_err == e.err, e.tag, "reset_err", reset_err, e.err);
            end else begin
                chk(!cmd_valid, "R2", "idle strobe", cmd_valid, 0);
                chk(run_status == mdl_run && reset_err == mdl_err, "R2", "idle state",
                    {reset_err, run_status}, {mdl_err, mdl_run});
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++; n_tests++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(!cmd_valid, "R1", "cmd_valid", cmd_valid, 0);
        chk(!reset_err, "R1", "reset_err", reset_err, 0);
        chk(run_status == 8'hFF, "R1", "run_status", run_status, 8'hFF);

        send(0, 3, 6'h2A, 0, 32'hFFFF_FFFF, "R2");   // stray bits ignored
        idle(2);
        send(2, 3, 6'h00, 0, 0, "R6");
        idle(1);
        send(0, 3, 6'h11, 0, 0, "R3");               // halted: blocked
        idle(1);
        send(3, 3, 6'h07, 0, 0, "R7");
        send(0, 3, 6'h12, 0, 0, "R3");               // running again
        idle(1);
        send(1, 5, 6'h05, 0, 0, "R5");               // illegal reset
        idle(2);
        clear_only("R9");
        idle(1);
        send(2, 5, 6'h00, 0, 0, "R6");
        send(1, 5, POR, 0, 0, "R4");
        idle(1);
        send(0, 8, 6'h01, 0, 0, "R8");
        send(2, 31, 6'h00, 0, 0, "R8");
        send(1, 9, 6'h3F, 0, 0, "R8");               // out of range: no flag
        idle(1);
        send(1, 2, 6'h02, 1, 0, "R9");               // set wins over clear
        idle(1);
        clear_only("R9");
        send(2, 0, 0, 0, 0, "R10");
        send(2, 1, 0, 0, 0, "R10");
        send(3, 0, 0, 0, 0, "R10");
        send(0, 1, 6'h15, 0, 0, "R10");
        send(0, 0, 6'h16, 0, 0, "R10");
        idle(4);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule